// File: doc/BRIEF.md
# Queue-Threshold Wake Trigger

This block lets a switch core sleep while packets pile up in its receive queue, and decides when the core should be woken to forward them. It watches three things: the number of bytes queued, the number of complete packets queued, and how long the oldest packet has been waiting. Each of these has a software-set limit. The first limit reached raises a single wake-enable line toward the power-state controller.

Packets are held back on purpose so that the core stays asleep longer. The wait timer bounds the extra latency this causes. The wake line is held until the controller reports that the core is running again. The line is then released and the watch restarts once the core goes back to sleep. The block is clocked from an always-running clock so that it keeps working while the core clock is stopped.

Top module: `qwake_trigger`

## Requirements
- R1: After reset, `wake_en` is 0, the wait timer is disarmed and the watch state is active.
- R2: While the core has been asleep (`core_awake` = 0) for at least one sampled cycle and `lim_bytes` is nonzero, `q_bytes` >= `lim_bytes` at a clock edge makes `wake_en` 1 after that edge.
- R3: Under the same conditions, `q_pkts` >= `lim_pkts` (nonzero) sets `wake_en` after that edge. With `lim_pkts` = 1, one complete packet is enough.
- R4: A `pkt_done` pulse sampled while the timer is disarmed arms it. If nothing else wakes the core first, `wake_en` rises exactly `lim_wait` edges after the edge that sampled the pulse.
- R5: Further `pkt_done` pulses while the timer is armed do not restart it. An edge that samples `q_pkts` = 0 with no `pkt_done` clears and disarms the timer. It stays disarmed until the next `pkt_done`.
- R6: The three triggers are combined with OR. Whichever is satisfied first raises `wake_en`.
- R7: A limit of 0 disables its trigger. With all three limits at 0, no queue contents and no pulse raise `wake_en`.
- R8: Once set, `wake_en` stays 1 until an edge samples `core_awake` = 1, and it is 0 after that edge. While `core_awake` stays 1, `wake_en` stays 0.
- R9: After an edge samples `core_awake` = 0 following the awake period, a trigger that still holds raises `wake_en` one edge later.
- R10: With the default widths, a byte limit of 5120 and a packet limit of 127 trigger at exactly those counts and not one below. Wait limits up to 16,777,215 cycles can be set, which covers 12,500,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_bytes | input | BYTE_W (14) | Bytes currently in the receive queue |
| q_pkts | input | PKT_W (8) | Complete packets currently in the receive queue |
| pkt_done | input | 1 | One-cycle pulse: a packet finished arriving |
| lim_bytes | input | BYTE_W (14) | Byte limit, 0 disables |
| lim_pkts | input | PKT_W (8) | Packet limit, 0 disables |
| lim_wait | input | WAIT_W (24) | Wait limit in cycles, 0 disables |
| core_awake | input | 1 | Power-state controller reports the core is running |
| wake_en | output | 1 | Request to wake the core |

## Verification
The bench checks the exact edge on which the wait timer fires. A timer that is off by one would fire a cycle early or late. A timer that restarts on every arrival would fire well after the expected edge. It checks that a drained queue disarms the timer and that a plain count change cannot rearm it. A design that kept a stale timer would raise a wake with no packet pending. The bench also checks each limit exactly at its value and one below, so a strict compare is caught. Finally, it checks how the request is held, released and raised again around `core_awake`. A design that dropped the request early, or that raised it while the core was awake, would differ from the cycle model on the first such edge.

// File: rtl/qwt_pkg.sv
package qwt_pkg;

    typedef enum logic [1:0] {
        WK_WATCH  = 2'd0,
        WK_ASSERT = 2'd1,
        WK_AWAKE  = 2'd2
    } wake_state_e;

endpackage

// File: rtl/qwt_level_cmp.sv
module qwt_level_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic limit_on;

    always_comb begin
        limit_on = (limit != '0);
        hit      = limit_on && (level >= limit);
    end
endmodule

// File: rtl/qwt_wait_timer.sv
module qwt_wait_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             q_empty,
    input  logic [CNT_W-1:0] limit,
    output logic             armed,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (pkt_done && !tmr_q.armed) begin
            // First complete packet into a drained queue starts the wait
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = CNT_ONE;
        end else if (q_empty && !pkt_done) begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end else if (tmr_q.armed && (tmr_q.cnt != CNT_MAX)) begin
            tmr_d.cnt = tmr_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    always_comb begin
        armed = tmr_q.armed;
        hit   = tmr_q.armed && (limit != '0) && (tmr_q.cnt >= limit);
    end
endmodule

// File: rtl/qwt_wake_fsm.sv
module qwt_wake_fsm
    import qwt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic core_awake,
    output logic wake_en
);
    typedef struct packed {
        wake_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            WK_WATCH: begin
                if (core_awake) begin
                    fsm_d.st = WK_AWAKE;
                end else if (trig) begin
                    fsm_d.st = WK_ASSERT;
                end
            end
            WK_ASSERT: begin
                if (core_awake) begin
                    fsm_d.st = WK_AWAKE;
                end
            end
            WK_AWAKE: begin
                if (!core_awake) begin
                    fsm_d.st = WK_WATCH;
                end
            end
            default: fsm_d.st = WK_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= WK_WATCH;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign wake_en = (fsm_q.st == WK_ASSERT);
endmodule

// File: rtl/qwake_trigger.sv
module qwake_trigger #(
    parameter int BYTE_W = 14,
    parameter int PKT_W  = 8,
    parameter int WAIT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] q_bytes,
    input  logic [PKT_W-1:0]  q_pkts,
    input  logic              pkt_done,
    input  logic [BYTE_W-1:0] lim_bytes,
    input  logic [PKT_W-1:0]  lim_pkts,
    input  logic [WAIT_W-1:0] lim_wait,
    input  logic              core_awake,
    output logic              wake_en
);
    logic byte_hit;
    logic pkt_hit;
    logic wait_hit;
    logic tmr_armed;
    logic q_empty;
    logic any_hit;

    assign q_empty = (q_pkts == '0);

    qwt_level_cmp #(.W(BYTE_W)) u_byte_cmp (
        .level (q_bytes),
        .limit (lim_bytes),
        .hit   (byte_hit)
    );

    qwt_level_cmp #(.W(PKT_W)) u_pkt_cmp (
        .level (q_pkts),
        .limit (lim_pkts),
        .hit   (pkt_hit)
    );

    qwt_wait_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_done (pkt_done),
        .q_empty  (q_empty),
        .limit    (lim_wait),
        .armed    (tmr_armed),
        .hit      (wait_hit)
    );

    assign any_hit = byte_hit | pkt_hit | wait_hit;

    qwt_wake_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (any_hit),
        .core_awake (core_awake),
        .wake_en    (wake_en)
    );
endmodule

// File: rtl/qwt_trigger_chk.sv
module qwt_trigger_chk #(
    parameter int BYTE_W = 14,
    parameter int PKT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PKT_W-1:0]  q_pkts,
    input logic              pkt_done,
    input logic              core_awake,
    input logic              wake_en,
    input logic              byte_hit,
    input logic              pkt_hit,
    input logic              wait_hit,
    input logic              armed
);
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && !core_awake) |=> wake_en); // R8

    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && core_awake) |=> !wake_en); // R8

    AST_QUIET_WHILE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_awake && !wake_en) |=> !wake_en); // R8

    AST_BYTE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_awake && $past(!core_awake) && byte_hit) |=> wake_en); // R2

    AST_PKT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_awake && $past(!core_awake) && pkt_hit) |=> wake_en); // R3

    AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_en) |-> $past(byte_hit || pkt_hit || wait_hit)); // R6

    AST_TIMER_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pkts == '0 && !pkt_done) |=> !armed); // R5

    AST_TIMER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> armed); // R4
endmodule

bind qwake_trigger qwt_trigger_chk #(.BYTE_W(BYTE_W), .PKT_W(PKT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_pkts     (q_pkts),
    .pkt_done   (pkt_done),
    .core_awake (core_awake),
    .wake_en    (wake_en),
    .byte_hit   (byte_hit),
    .pkt_hit    (pkt_hit),
    .wait_hit   (wait_hit),
    .armed      (tmr_armed)
);

// File: tb/qwake_trigger_test.sv
`timescale 1ns/1ps
module qwake_trigger_test;
    localparam int BYTE_W = 14;
    localparam int PKT_W  = 8;
    localparam int WAIT_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BYTE_W-1:0] q_bytes = '0;
    logic [PKT_W-1:0]  q_pkts = '0;
    logic              pkt_done = 1'b0;
    logic [BYTE_W-1:0] lim_bytes = '0;
    logic [PKT_W-1:0]  lim_pkts = '0;
    logic [WAIT_W-1:0] lim_wait = '0;
    logic              core_awake = 1'b0;
    logic              wake_en;

    int    tests = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    qwake_trigger #(.BYTE_W(BYTE_W), .PKT_W(PKT_W), .WAIT_W(WAIT_W)) uut (
        .clk(clk), .rst_n(rst_n), .q_bytes(q_bytes), .q_pkts(q_pkts),
        .pkt_done(pkt_done), .lim_bytes(lim_bytes), .lim_pkts(lim_pkts),
        .lim_wait(lim_wait), .core_awake(core_awake), .wake_en(wake_en)
    );

    // Behavioural reference: 0 watching, 1 requesting, 2 core awake
    int m_st = 0;
    bit m_arm = 0;
    longint m_cnt = 0;
    localparam longint CNT_TOP = (64'd1 << WAIT_W) - 1;

    always @(posedge clk) begin
        bit bh, ph, wh, tr;
        if (!rst_n) begin
            m_st = 0; m_arm = 0; m_cnt = 0;
        end else begin
            bh = (lim_bytes != 0) && (int'(q_bytes) >= int'(lim_bytes));
            ph = (lim_pkts != 0) && (int'(q_pkts) >= int'(lim_pkts));
            wh = m_arm && (lim_wait != 0) && (m_cnt >= longint'(lim_wait));
            tr = bh || ph || wh;
            if (m_st == 0) begin
                if (core_awake) m_st = 2; else if (tr) m_st = 1;
            end else if (m_st == 1) begin
                if (core_awake) m_st = 2;
            end else begin
                if (!core_awake) m_st = 0;
            end
            if (pkt_done && !m_arm) begin
                m_arm = 1; m_cnt = 1;
            end else if (q_pkts == 0 && !pkt_done) begin
                m_arm = 0; m_cnt = 0;
            end else if (m_arm && m_cnt < CNT_TOP) begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            tests++;
            if (wake_en !== (m_st == 1)) begin
                fails++;
                $display("FAIL %s cycle model: wake_en=%0b expected %0b at %0t",
                         cur_req, wake_en, (m_st == 1), $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp);
        tests++;
        if (wake_en !== exp) begin
            fails++;
            $display("FAIL %s wake_en=%0b expected %0b at %0t", req, wake_en, exp, $time);
        end
    endtask

    task automatic ack_clear();
        core_awake = 1'b1;
        q_bytes = '0; q_pkts = '0; pkt_done = 1'b0;
        lim_bytes = '0; lim_pkts = '0; lim_wait = '0;
        step(2);
        core_awake = 1'b0;
        step(2);
        chk("R8", 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R1 watchdog: run=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1", 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1", 1'b0);

        // Byte trigger, hold, release, re-raise
        cur_req = "R2";
        lim_bytes = 14'd100; q_bytes = 14'd99;
        step(2); chk("R2", 1'b0);
        q_bytes = 14'd100;
        step(1); chk("R2", 1'b1);
        cur_req = "R8";
        step(3); chk("R8", 1'b1);
        core_awake = 1'b1;
        step(1); chk("R8", 1'b0);
        step(2); chk("R8", 1'b0);
        cur_req = "R9";
        core_awake = 1'b0;
        step(1); chk("R9", 1'b0);
        step(1); chk("R9", 1'b1);
        ack_clear();

        // Packet limit of one
        cur_req = "R3";
        lim_pkts = 8'd1; q_pkts = 8'd1; pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        chk("R3", 1'b1);
        ack_clear();

        // Large limits exactly at and below threshold
        cur_req = "R10";
        lim_bytes = 14'd5120; q_bytes = 14'd5119;
        step(2); chk("R10", 1'b0);
        q_bytes = 14'd5120;
        step(1); chk("R10", 1'b1);
        ack_clear();
        cur_req = "R10";
        lim_pkts = 8'd127; q_pkts = 8'd126;
        step(2); chk("R10", 1'b0);
        q_pkts = 8'd127;
        step(1); chk("R10", 1'b1);
        ack_clear();

        // Wait timer exact edge; second arrival does not restart
        cur_req = "R4";
        lim_wait = 24'd20; q_pkts = 8'd1; pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(4); pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(14); chk("R5", 1'b0);
        step(1); chk("R4", 1'b1);
        ack_clear();

        // Drain disarms; count alone cannot rearm
        cur_req = "R5";
        lim_wait = 24'd20; q_pkts = 8'd1; pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(10);
        q_pkts = 8'd0;
        step(1);
        q_pkts = 8'd1;
        step(25); chk("R5", 1'b0);
        pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(19); chk("R5", 1'b0);
        step(1); chk("R5", 1'b1);
        ack_clear();

        // All limits zero
        cur_req = "R7";
        q_bytes = 14'd8000; q_pkts = 8'd200; pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(30); chk("R7", 1'b0);
        q_bytes = '0; q_pkts = '0;
        step(2);

        // OR of triggers: bytes win before timer and packet count
        cur_req = "R6";
        lim_bytes = 14'd1000; lim_pkts = 8'd10; lim_wait = 24'd30;
        q_bytes = 14'd500; q_pkts = 8'd3; pkt_done = 1'b1;
        step(1); pkt_done = 1'b0;
        step(5); chk("R6", 1'b0);
        q_bytes = 14'd1000;
        step(1); chk("R6", 1'b1);
        ack_clear();

        // Trigger while already awake stays quiet, then fires after sleep
        cur_req = "R8";
        core_awake = 1'b1; lim_bytes = 14'd10; q_bytes = 14'd50;
        step(3); chk("R8", 1'b0);
        cur_req = "R9";
        core_awake = 1'b0;
        step(1); chk("R9", 1'b0);
        step(1); chk("R9", 1'b1);
        ack_clear();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule